// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

This block watches the data accesses of a processor core and reports which of its watch slots each access touches. There are four slots by default. Each one holds a linear watch address, an enable, an access-kind mask and a watch span of 1, 2 or 4 bytes. Every access strobe carries a start address, a byte count and a read/write flag. The access is compared against all slots in parallel. Each slot that overlaps it sets its own sticky bit in an event vector, which the exception logic downstream samples.

The slots are loaded through a small register write port. The same port clears event bits by mask. A resume input comes from the core's flag state, and while it is high no slot records anything. Instruction watchpoints and raising the trap are handled outside this block.

Top module: `dbg_watch_match`

## Requirements
- R1: After reset every event bit is 0 and every slot is disabled.
- R2: A write with `cfg_sel` equal to k (0 to NUM_SLOTS-1) loads slot k's watch address. Select NUM_SLOTS loads the control word. Select NUM_SLOTS+1 clears the event bits that are 1 in `cfg_wdata[NUM_SLOTS-1:0]`. Other select values change nothing.
- R3: Control word layout for slot i: enable at bit i, kind mask at bits [NUM_SLOTS+2i+1 : NUM_SLOTS+2i], span code at bits [3*NUM_SLOTS+2i+1 : 3*NUM_SLOTS+2i].
- R4: A read carries kind code 2'b11 and a write carries 2'b01. A slot responds only when its kind mask ANDed with the access code is nonzero. Mask 00 never matches, 01 matches reads and writes, 10 matches reads only, and 11 matches both.
- R5: Span codes are the same for slots and accesses: 00 means 1 byte, 01 means 2 bytes, 11 means 4 bytes, and the spare code 10 means 1 byte.
- R6: A slot hits when the access start is at or below the watch address and the start plus the access length is above it.
- R7: A slot also hits when the access start is above the watch address and below the watch address plus the slot span.
- R8: The sums in R6 and R7 are formed one bit wider than the address, so ranges at the top of memory do not wrap to zero.
- R9: While `resume_flag` is high, an access sets no event bit.
- R10: A disabled slot, and any cycle without `acc_valid`, sets no event bit.
- R11: Event bits stay set until cleared. A clear affects only the bits in its mask.
- R12: Several slots hit by one access all set their bits. When a hit and a clear of the same bit fall in one cycle, the bit ends up set.
- R13: An event bit becomes visible at `hit_events` right after the clock edge that samples the access, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | CSEL_W (3) | Register select |
| cfg_wdata | input | ADDR_W (32) | Register write data |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | ADDR_W (32) | Linear start address of the access |
| acc_len | input | 2 | Access span code (R5) |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| resume_flag | input | 1 | Suppresses all matching while high |
| hit_events | output | NUM_SLOTS (4) | Sticky per-slot hit bits |

## Verification
The assertions assume that a resume cycle and an event clear are never issued in the same cycle. Under that assumption, a resume cycle leaves the event vector unchanged. They also take the core's access fields as meaningless while `acc_valid` is low, and they take reset as asynchronous. The stimulus changes every input on the falling clock edge and holds each access for exactly one rising edge. It never pairs resume with a clear, and the one cycle that combines a clear with a hit is driven with resume low.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

   // Access kind codes presented to the slot kind masks
   localparam logic [1:0] KIND_READ  = 2'b11;
   localparam logic [1:0] KIND_WRITE = 2'b01;

   typedef enum logic [1:0] {
      SPAN_1   = 2'b00,
      SPAN_2   = 2'b01,
      SPAN_SPR = 2'b10,
      SPAN_4   = 2'b11
   } span_code_e;

   // Byte count for a span code; the spare code counts as a single byte
   function automatic logic [2:0] span_bytes(input logic [1:0] code);
      logic [2:0] n;
      case (span_code_e'(code))
         SPAN_2:  n = 3'd2;
         SPAN_4:  n = 3'd4;
         default: n = 3'd1;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dbgw_cfg_regs.sv
module dbgw_cfg_regs #(
   parameter int ADDR_W    = 32,
   parameter int NUM_SLOTS = 4,
   parameter int CSEL_W    = 3
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic [CSEL_W-1:0]                   cfg_sel,
   input  logic [ADDR_W-1:0]                   cfg_wdata,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_addr,
   output logic [NUM_SLOTS-1:0]                slot_en,
   output logic [NUM_SLOTS-1:0][1:0]           slot_kind,
   output logic [NUM_SLOTS-1:0][1:0]           slot_span,
   output logic [NUM_SLOTS-1:0]                clr_mask
);

   localparam logic [CSEL_W-1:0] SEL_CTRL  = CSEL_W'(NUM_SLOTS);
   localparam logic [CSEL_W-1:0] SEL_CLEAR = CSEL_W'(NUM_SLOTS + 1);
   localparam int KIND_BASE = NUM_SLOTS;
   localparam int SPAN_BASE = 3 * NUM_SLOTS;

   logic ctrl_wr;
   assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);

   // One address register per slot
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_addr
      localparam logic [CSEL_W-1:0] MY_SEL = CSEL_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_addr[g] <= '0;
         end else if (cfg_we && (cfg_sel == MY_SEL)) begin
            slot_addr[g] <= cfg_wdata;
         end
      end
   end

   // Packed control word: enables, kind masks, span codes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_en   <= '0;
         slot_kind <= '0;
         slot_span <= '0;
      end else if (ctrl_wr) begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_en[i]   <= cfg_wdata[i];
            slot_kind[i] <= cfg_wdata[KIND_BASE + 2*i +: 2];
            slot_span[i] <= cfg_wdata[SPAN_BASE + 2*i +: 2];
         end
      end
   end

   assign clr_mask = (cfg_we && (cfg_sel == SEL_CLEAR)) ? cfg_wdata[NUM_SLOTS-1:0] : '0;

endmodule

// File: rtl/dbgw_slot_cmp.sv
module dbgw_slot_cmp
   import dbgw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter bit CARRY_GUARD = 1'b1
) (
   input  logic              gate,
   input  logic              slot_en,
   input  logic [1:0]        slot_kind,
   input  logic [1:0]        slot_span,
   input  logic [ADDR_W-1:0] wp_addr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_len,
   input  logic [1:0]        acc_kind,
   output logic              hit
);

   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] acc_lo, wp_lo, acc_end, wp_end;
   logic             kind_ok, fwd_ovl, bwd_ovl;

   assign acc_lo = {1'b0, acc_addr};
   assign wp_lo  = {1'b0, wp_addr};

   if (CARRY_GUARD) begin : g_wide
      assign acc_end = acc_lo + SUM_W'(span_bytes(acc_len));
      assign wp_end  = wp_lo  + SUM_W'(span_bytes(slot_span));
   end else begin : g_wrap
      assign acc_end = {1'b0, acc_addr + ADDR_W'(span_bytes(acc_len))};
      assign wp_end  = {1'b0, wp_addr  + ADDR_W'(span_bytes(slot_span))};
   end

   assign kind_ok = |(slot_kind & acc_kind);
   assign fwd_ovl = (acc_lo <= wp_lo) && (acc_end > wp_lo);
   assign bwd_ovl = (acc_lo >  wp_lo) && (acc_lo < wp_end);
   assign hit     = gate && slot_en && kind_ok && (fwd_ovl || bwd_ovl);

endmodule

// File: rtl/dbgw_event_reg.sv
module dbgw_event_reg #(
   parameter int NUM_SLOTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] set_vec,
   input  logic [NUM_SLOTS-1:0] clr_vec,
   output logic [NUM_SLOTS-1:0] events
);

   // A set wins over a clear of the same bit in one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         events <= '0;
      end else begin
         events <= (events & ~clr_vec) | set_vec;
      end
   end

endmodule

// File: rtl/dbg_watch_match.sv
module dbg_watch_match
   import dbgw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_SLOTS   = 4,
   parameter bit CARRY_GUARD = 1'b1,
   localparam int CSEL_W     = $clog2(NUM_SLOTS + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CSEL_W-1:0]    cfg_sel,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   input  logic                 acc_valid,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic [1:0]           acc_len,
   input  logic                 acc_write,
   input  logic                 resume_flag,
   output logic [NUM_SLOTS-1:0] hit_events
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > 8) begin : g_bad_slots
      $error("dbg_watch_match: NUM_SLOTS must be 1..8");
   end
   if (5 * NUM_SLOTS > ADDR_W) begin : g_bad_ctrl
      $error("dbg_watch_match: control word does not fit in ADDR_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("dbg_watch_match: ADDR_W too small");
   end

   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
   logic [NUM_SLOTS-1:0]             slot_en;
   logic [NUM_SLOTS-1:0][1:0]        slot_kind;
   logic [NUM_SLOTS-1:0][1:0]        slot_span;
   logic [NUM_SLOTS-1:0]             clr_mask;
   logic [NUM_SLOTS-1:0]             slot_hit;
   logic [1:0]                       acc_kind;
   logic                             gate;

   dbgw_cfg_regs #(
      .ADDR_W    (ADDR_W),
      .NUM_SLOTS (NUM_SLOTS),
      .CSEL_W    (CSEL_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .slot_addr (slot_addr),
      .slot_en   (slot_en),
      .slot_kind (slot_kind),
      .slot_span (slot_span),
      .clr_mask  (clr_mask)
   );

   assign acc_kind = acc_write ? KIND_WRITE : KIND_READ;
   assign gate     = acc_valid && !resume_flag && (|slot_en);

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      dbgw_slot_cmp #(
         .ADDR_W      (ADDR_W),
         .CARRY_GUARD (CARRY_GUARD)
      ) u_cmp (
         .gate      (gate),
         .slot_en   (slot_en[g]),
         .slot_kind (slot_kind[g]),
         .slot_span (slot_span[g]),
         .wp_addr   (slot_addr[g]),
         .acc_addr  (acc_addr),
         .acc_len   (acc_len),
         .acc_kind  (acc_kind),
         .hit       (slot_hit[g])
      );
   end

   dbgw_event_reg #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (slot_hit),
      .clr_vec (clr_mask),
      .events  (hit_events)
   );

endmodule

// File: rtl/dbgw_checker.sv
module dbgw_checker #(
   parameter int NUM_SLOTS = 4,
   parameter int CSEL_W    = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [CSEL_W-1:0]    cfg_sel,
   input logic                 acc_valid,
   input logic                 resume_flag,
   input logic [NUM_SLOTS-1:0] slot_en,
   input logic [NUM_SLOTS-1:0] hit_events
);

   localparam logic [CSEL_W-1:0] SEL_CLEAR = CSEL_W'(NUM_SLOTS + 1);

   logic clr_wr;
   assign clr_wr = cfg_we && (cfg_sel == SEL_CLEAR);

   AST_RESET_EMPTY: assert property (@(posedge clk)
      !rst_n |=> hit_events == '0);                                   // R1

   AST_RESUME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_flag && !clr_wr) |=> $stable(hit_events));              // R9

   AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((hit_events & $past(hit_events)) == $past(hit_events))); // R11

   AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> ((hit_events & ~$past(hit_events)) == '0));      // R10

   AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_events & ~$past(hit_events) & ~$past(slot_en)) == '0);     // R10

endmodule

bind dbg_watch_match dbgw_checker #(
   .NUM_SLOTS (NUM_SLOTS),
   .CSEL_W    (CSEL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_sel     (cfg_sel),
   .acc_valid   (acc_valid),
   .resume_flag (resume_flag),
   .slot_en     (slot_en),
   .hit_events  (hit_events)
);

// File: tb/test_dbg_watch_match.sv
module test_dbg_watch_match;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_len = '0;
   logic        acc_write = 1'b0;
   logic        resume_flag = 1'b0;
   logic [3:0]  hit_events;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   dbg_watch_match i_dbg_watch_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_wdata   (cfg_wdata),
      .acc_valid   (acc_valid),
      .acc_addr    (acc_addr),
      .acc_len     (acc_len),
      .acc_write   (acc_write),
      .resume_flag (resume_flag),
      .hit_events  (hit_events)
   );

   // Control word per R3 with four slots: kinds/spans packed {s3,s2,s1,s0}
   function automatic logic [31:0] mk_ctrl(input logic [3:0] en,
                                           input logic [7:0] kinds,
                                           input logic [7:0] spans);
      return {12'b0, spans, kinds, en};
   endfunction

   localparam logic [7:0] KINDS = {2'b10, 2'b11, 2'b01, 2'b11};
   localparam logic [7:0] SPANS = {2'b00, 2'b11, 2'b01, 2'b11};

   task automatic check(input string tag, input logic [3:0] exp);
      checks++;
      if (hit_events !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, hit_events, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_all();
      reg_write(3'd5, 32'hF);
   endtask

   task automatic access(input logic [31:0] a, input logic [1:0] l,
                         input logic wr, input logic rs);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_len = l; acc_write = wr; resume_flag = rs;
      @(negedge clk);
      acc_valid = 1'b0; resume_flag = 1'b0;
   endtask

   task automatic setup_slots();
      reg_write(3'd0, 32'h0000_1000);
      reg_write(3'd1, 32'h0000_2002);
      reg_write(3'd2, 32'hFFFF_FFFE);
      reg_write(3'd3, 32'h0000_3000);
      reg_write(3'd4, mk_ctrl(4'hF, KINDS, SPANS));
   endtask

   task automatic t_reset();
      check("R1 reset events", 4'b0000);
      access(32'h0000_0000, 2'b11, 1'b0, 1'b0);   // slots disabled at reset, address 0 overlaps slot resets
      check("R1 slots disabled after reset", 4'b0000);
   endtask

   task automatic t_forward();
      clear_all();
      access(32'h0000_0FFE, 2'b11, 1'b0, 1'b0);
      check("R6 forward overlap", 4'b0001);
      clear_all();
      access(32'h0000_0FFC, 2'b11, 1'b0, 1'b0);
      check("R6 end equals watch address", 4'b0000);
   endtask

   task automatic t_backward();
      clear_all();
      access(32'h0000_1003, 2'b00, 1'b0, 1'b0);
      check("R7 start inside slot span", 4'b0001);
      clear_all();
      access(32'h0000_1004, 2'b00, 1'b0, 1'b0);
      check("R7 start at span end", 4'b0000);
   endtask

   task automatic t_kinds();
      clear_all();
      access(32'h0000_2002, 2'b01, 1'b1, 1'b0);
      check("R4 write hits mask 01", 4'b0010);
      clear_all();
      access(32'h0000_2003, 2'b00, 1'b0, 1'b0);
      check("R4 read hits mask 01", 4'b0010);
      clear_all();
      access(32'h0000_3000, 2'b00, 1'b0, 1'b0);
      check("R4 read hits mask 10", 4'b1000);
      clear_all();
      access(32'h0000_3000, 2'b00, 1'b1, 1'b0);
      check("R4 write misses mask 10", 4'b0000);
   endtask

   task automatic t_spans();
      clear_all();
      access(32'h0000_3001, 2'b00, 1'b0, 1'b0);
      check("R5 slot span code 00 is one byte", 4'b0000);
      access(32'h0000_0FFF, 2'b10, 1'b0, 1'b0);
      check("R5 access spare code is one byte", 4'b0000);
      access(32'h0000_0FFF, 2'b01, 1'b0, 1'b0);
      check("R5 access code 01 is two bytes", 4'b0001);
   endtask

   task automatic t_top_of_memory();
      clear_all();
      access(32'hFFFF_FFFF, 2'b00, 1'b0, 1'b0);
      check("R8 backward at top of memory", 4'b0100);
      clear_all();
      access(32'hFFFF_FFFC, 2'b11, 1'b1, 1'b0);
      check("R8 forward at top of memory", 4'b0100);
   endtask

   task automatic t_resume();
      clear_all();
      access(32'h0000_1000, 2'b00, 1'b0, 1'b1);
      check("R9 resume suppresses", 4'b0000);
      access(32'h0000_1000, 2'b00, 1'b0, 1'b0);
      check("R9 matching after resume drops", 4'b0001);
   endtask

   task automatic t_disabled();
      clear_all();
      reg_write(3'd4, mk_ctrl(4'b1110, KINDS, SPANS));
      access(32'h0000_1000, 2'b00, 1'b0, 1'b0);
      check("R10 R3 disabled slot", 4'b0000);
      reg_write(3'd4, mk_ctrl(4'hF, KINDS, SPANS));
      @(negedge clk);
      acc_addr = 32'h0000_1000; acc_len = 2'b00; acc_write = 1'b0; acc_valid = 1'b0;
      @(negedge clk);
      check("R10 no strobe", 4'b0000);
      reg_write(3'd6, 32'hFFFF_FFFF);
      access(32'h0000_1000, 2'b00, 1'b0, 1'b0);
      check("R2 unused select leaves slots intact", 4'b0001);
   endtask

   task automatic t_sticky();
      clear_all();
      access(32'h0000_1000, 2'b00, 1'b0, 1'b0);
      access(32'h0000_5000, 2'b00, 1'b0, 1'b0);
      check("R11 bit stays after miss", 4'b0001);
      access(32'h0000_2002, 2'b00, 1'b1, 1'b0);
      reg_write(3'd5, 32'h2);
      check("R11 partial clear", 4'b0001);
      reg_write(3'd5, 32'h1);
      check("R11 clear remaining", 4'b0000);
   endtask

   task automatic t_multi();
      clear_all();
      reg_write(3'd1, 32'h0000_1002);
      access(32'h0000_1000, 2'b11, 1'b0, 1'b0);
      check("R12 R2 two slots in one access", 4'b0011);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'hF;
      acc_valid = 1'b1; acc_addr = 32'h0000_1000; acc_len = 2'b00; acc_write = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0; acc_valid = 1'b0;
      check("R12 set beats clear", 4'b0001);
   endtask

   task automatic t_timing();
      clear_all();
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 32'h0000_1000; acc_len = 2'b00; acc_write = 1'b0;
      #1;
      check("R13 no event before edge", 4'b0000);
      @(negedge clk);
      acc_valid = 1'b0;
      check("R13 event after edge", 4'b0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      setup_slots();
      t_forward();
      t_backward();
      t_kinds();
      t_spans();
      t_top_of_memory();
      t_resume();
      t_disabled();
      t_sticky();
      t_multi();
      t_timing();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog R13 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule